// File: doc/BRIEF.md
# SPI Serial Clock Prescaler with Setting Search

This block makes the serial clock for an SPI master out of the main clock. It uses two dividers in cascade. A coarse stage divides the main clock by a power of two, chosen by a 2-bit coarse code. A fine stage then divides the result by twice a 6-bit fine count plus one. The fine count is only legal from 4 to 63. The divider drives a serial clock whose idle level is selectable. It also drives a one-cycle pulse on each serial clock transition, and it reports the setting currently in force. The setting is copied from the configuration inputs only while the divider is disabled. Both counters restart from zero on enable, so the first half period after enable is always full length.

A separate searcher turns a requested main-to-serial clock ratio into a legal coarse code and fine count. It tries the coarse codes from smallest to largest, one per cycle, and takes the first one whose fine count fits. It clamps to the fastest setting when the request is too fast and to the slowest setting when it is too slow.

Requests enter on a valid/ready pair and results leave on a valid/ready pair. A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the result has been taken. A result is held, unchanged, while `res_valid` is high and `res_ready` is low. It is released in the cycle where both are high.

Top module: `spi_baud_gen`

## Requirements
- R1: After reset `act_div` is 0, `act_brg` is 4, `sclk_edge` is 0, `res_valid` is 0 and `req_ready` is 1.
- R2: While `en` is high, `sclk_edge` pulses once every (2 << act_div) * (act_brg + 1) main clock cycles. The first pulse comes that many cycles after the first cycle sampled with `en` high.
- R3: For a request ratio N, the searcher tries coarse code d = 0, 1, 2, 3 in order and computes q = N / (4 << d), rounded down. It returns the first d with q <= 64, with fine count q - 1. `res_brg` is always in the range 4 to 63.
- R4: If q < 5 at the accepted step (a request that is too fast), the result is fine count 4 with that coarse code. For any N below 20 this is coarse code 0.
- R5: If no coarse code up to 3 is accepted (N >= 2080 at the default widths), the result is coarse code 3 with fine count 63.
- R6: `cfg_div` and `cfg_brg` are copied to `act_div` and `act_brg` on every clock edge where `en` is low. While `en` stays high, changes on them have no effect on `act_div`, `act_brg` or the period. The value used after enable is the one present in the last cycle with `en` low.
- R7: While `en` is low, `sclk` equals `cpol` one cycle later. While `en` is high, `sclk` changes level exactly on the edges that raise `sclk_edge`.
- R8: A `cfg_brg` value below 4 is applied as 4.
- R9: A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is low until the result is taken. While `res_valid` is high and `res_ready` is low, `res_div` and `res_brg` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Ratio request is valid |
| req_ready | output | 1 | Searcher can take a request |
| req_ratio | input | 16 | Requested main-to-serial clock ratio |
| res_valid | output | 1 | Search result is valid |
| res_ready | input | 1 | Consumer takes the result |
| res_div | output | 2 | Chosen coarse code |
| res_brg | output | 6 | Chosen fine count (4 to 63) |
| en | input | 1 | Divider enable |
| cfg_div | input | 2 | Coarse code to apply while disabled |
| cfg_brg | input | 6 | Fine count to apply while disabled |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock |
| sclk_edge | output | 1 | One-cycle pulse on each serial clock transition |
| act_div | output | 2 | Coarse code in force |
| act_brg | output | 6 | Fine count in force |

## Verification
Two events can fall in the same cycle: the copy of a new setting, and the start of counting when `en` rises. The bench holds one fine count while `en` is low. In the cycle where it raises `en`, it changes `cfg_brg` to a different value. The half period it then measures must match the older setting, and the setting reported afterwards must be the older one too. The same test changes the setting while the divider runs and expects the period to stay the same. It then expects the new setting to appear on the first edge with `en` low.

// File: rtl/baud_pkg.sv
package baud_pkg;
  parameter int DIV_W   = 2;
  parameter int BRG_W   = 6;
  parameter int BRG_MIN = 4;
  parameter int BRG_MAX = 63;
  parameter int RATIO_W = 16;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_SEARCH = 2'd1,
    S_DONE   = 2'd2
  } sel_state_t;
endpackage

// File: rtl/baud_divider.sv
module baud_divider
  import baud_pkg::*;
#(
  parameter int DW   = DIV_W,
  parameter int BW   = BRG_W,
  parameter int BMIN = BRG_MIN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] cfg_div,
  input  logic [BW-1:0] cfg_brg,
  input  logic          cpol,
  output logic          sclk,
  output logic          sclk_edge,
  output logic [DW-1:0] act_div,
  output logic [BW-1:0] act_brg
);
  localparam int PRE_W = (1 << DW) + 1;

  logic [PRE_W-1:0] pre_cnt, pre_lim;
  logic [BW-1:0]    fine_cnt, brg_eff;
  logic             tick, half_done, seen_q;

  assign brg_eff   = (cfg_brg < BW'(BMIN)) ? BW'(BMIN) : cfg_brg;
  assign pre_lim   = (PRE_W'(2) << act_div) - PRE_W'(1);
  assign tick      = en && (pre_cnt == pre_lim);
  assign half_done = tick && (fine_cnt == act_brg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_div   <= '0;
      act_brg   <= BW'(BMIN);
      pre_cnt   <= '0;
      fine_cnt  <= '0;
      sclk      <= 1'b0;
      sclk_edge <= 1'b0;
      seen_q    <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      if (!en) begin
        act_div   <= cfg_div;
        act_brg   <= brg_eff;
        pre_cnt   <= '0;
        fine_cnt  <= '0;
        sclk      <= cpol;
        sclk_edge <= 1'b0;
      end else begin
        sclk_edge <= half_done;
        pre_cnt   <= tick ? '0 : pre_cnt + PRE_W'(1);
        if (tick) fine_cnt <= half_done ? '0 : fine_cnt + BW'(1);
        if (half_done) sclk <= ~sclk;
      end
    end
  end

  // R6: setting frozen while running
  p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && en && $past(en)) |-> ($stable(act_div) && $stable(act_brg)));

  // R7: idle level follows polarity input
  p_idle_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !$past(en)) |-> (sclk == $past(cpol)));

  // R7: a pulse marks a real level change
  p_edge_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && sclk_edge) |-> (sclk != $past(sclk)));

  // R8: fine count in force never below the legal floor
  p_brg_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    act_brg >= BW'(BMIN));
endmodule

// File: rtl/baud_select.sv
module baud_select
  import baud_pkg::*;
#(
  parameter int RW   = RATIO_W,
  parameter int DW   = DIV_W,
  parameter int BW   = BRG_W,
  parameter int BMIN = BRG_MIN,
  parameter int BMAX = BRG_MAX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [RW-1:0] req_ratio,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_div,
  output logic [BW-1:0] res_brg
);
  localparam logic [DW-1:0] IDX_LAST = DW'((1 << DW) - 1);

  sel_state_t    state;
  logic [RW-1:0] ratio_q, quot;
  logic [DW-1:0] idx;
  logic [DW:0]   shamt;
  logic          too_fast, fits;

  assign shamt     = {1'b0, idx} + (DW + 1)'(2);
  assign quot      = ratio_q >> shamt;
  assign too_fast  = quot < RW'(BMIN + 1);
  assign fits      = quot <= RW'(BMAX + 1);
  assign req_ready = (state == S_IDLE);
  assign res_valid = (state == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ratio_q <= '0;
      idx     <= '0;
      res_div <= '0;
      res_brg <= BW'(BMIN);
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          ratio_q <= req_ratio;
          idx     <= '0;
          state   <= S_SEARCH;
        end
        S_SEARCH: begin
          if (too_fast) begin
            res_div <= idx;
            res_brg <= BW'(BMIN);
            state   <= S_DONE;
          end else if (fits) begin
            res_div <= idx;
            res_brg <= BW'(quot - RW'(1));
            state   <= S_DONE;
          end else if (idx == IDX_LAST) begin
            res_div <= IDX_LAST;
            res_brg <= BW'(BMAX);
            state   <= S_DONE;
          end else begin
            idx <= idx + DW'(1);
          end
        end
        S_DONE: if (res_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3: result always within the legal fine range
  p_brg_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_brg >= BW'(BMIN) && res_brg <= BW'(BMAX)));

  // R9: result held under back-pressure
  p_res_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_div) && $stable(res_brg)));

  // R9: no new request while a result is pending
  p_no_take_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
  import baud_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [RATIO_W-1:0] req_ratio,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [DIV_W-1:0]   res_div,
  output logic [BRG_W-1:0]   res_brg,
  input  logic               en,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic [BRG_W-1:0]   cfg_brg,
  input  logic               cpol,
  output logic               sclk,
  output logic               sclk_edge,
  output logic [DIV_W-1:0]   act_div,
  output logic [BRG_W-1:0]   act_brg
);
  baud_select #(
    .RW(RATIO_W), .DW(DIV_W), .BW(BRG_W), .BMIN(BRG_MIN), .BMAX(BRG_MAX)
  ) u_sel (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_ratio(req_ratio),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_div(res_div), .res_brg(res_brg)
  );

  baud_divider #(
    .DW(DIV_W), .BW(BRG_W), .BMIN(BRG_MIN)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cfg_div(cfg_div), .cfg_brg(cfg_brg), .cpol(cpol),
    .sclk(sclk), .sclk_edge(sclk_edge),
    .act_div(act_div), .act_brg(act_brg)
  );
endmodule

// File: tb/tb_spi_baud_gen.sv
`timescale 1ns/1ps
module tb_spi_baud_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, res_ready = 1'b0;
  logic [15:0] req_ratio = '0;
  logic        req_ready, res_valid;
  logic [1:0]  res_div, act_div;
  logic [5:0]  res_brg, act_brg;
  logic        en = 1'b0, cpol = 1'b0;
  logic [1:0]  cfg_div = '0;
  logic [5:0]  cfg_brg = 6'd4;
  logic        sclk, sclk_edge;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_baud_gen dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic run_sel(input int n);
    int ed, eb, q, w;
    bit found;
    found = 0; ed = 3; eb = 63;
    for (int d = 0; d < 4 && !found; d++) begin
      q = n / (4 << d);
      if (q < 5) begin ed = d; eb = 4; found = 1; end
      else if (q <= 64) begin ed = d; eb = q - 1; found = 1; end
    end
    @(negedge clk);
    req_valid = 1'b1; req_ratio = 16'(n);
    @(negedge clk);
    req_valid = 1'b0;
    w = 0;
    while (!res_valid && w < 20) begin @(negedge clk); w++; end
    if (n < 20)
      chk(res_div == 2'(ed) && res_brg == 6'(eb), "R4", {res_div, res_brg}, {ed[1:0], eb[5:0]});
    else if (n >= 2080)
      chk(res_div == 2'(ed) && res_brg == 6'(eb), "R5", {res_div, res_brg}, {ed[1:0], eb[5:0]});
    else
      chk(res_div == 2'(ed) && res_brg == 6'(eb), "R3", {res_div, res_brg}, {ed[1:0], eb[5:0]});
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  task automatic half(output int c);
    c = 0;
    do begin @(negedge clk); c++; end while (!sclk_edge && c < 3000);
  endtask

  task automatic run_div(input int d, input int b, input bit pol);
    int eb, h, c;
    eb = (b < 4) ? 4 : b;
    h = (2 << d) * (eb + 1);
    @(negedge clk);
    en = 1'b0; cfg_div = 2'(d); cfg_brg = 6'(b); cpol = pol;
    @(negedge clk);
    @(negedge clk);
    chk(sclk == pol, "R7", sclk, pol);
    if (b < 4) chk(act_brg == 6'(eb), "R8", act_brg, eb);
    else chk(act_div == 2'(d) && act_brg == 6'(b), "R6", {act_div, act_brg}, {d[1:0], b[5:0]});
    en = 1'b1;
    half(c);
    chk(c == h, "R2", c, h);
    chk(sclk == !pol, "R7", sclk, !pol);
    half(c);
    chk(c == h, "R2", c, h);
    en = 1'b0;
    @(negedge clk);
    chk(sclk == pol && !sclk_edge, "R7", sclk, pol);
  endtask

  initial begin
    int c, w;
    logic [1:0] hd;
    logic [5:0] hb;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(act_div == 0 && act_brg == 4, "R1", {act_div, act_brg}, 4);
    chk(!sclk_edge && !res_valid && req_ready, "R1", {sclk_edge, res_valid, req_ready}, 1);
    rst_n = 1'b1;

    for (int n = 0; n <= 2200; n++) run_sel(n);
    run_sel(4095);
    run_sel(65535);

    // R9 handshake and hold
    @(negedge clk);
    req_valid = 1'b1; req_ratio = 16'd1000;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9", req_ready, 0);
    w = 0;
    while (!res_valid && w < 20) begin @(negedge clk); w++; end
    hd = res_div; hb = res_brg;
    repeat (5) @(negedge clk);
    chk(res_valid && res_div == hd && res_brg == hb, "R9", {res_valid, res_div, res_brg}, {1'b1, hd, hb});
    chk(!req_ready, "R9", req_ready, 0);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(!res_valid && req_ready, "R9", {res_valid, req_ready}, 1);

    for (int d = 0; d < 4; d++) begin
      run_div(d, 4, d[0]);
      run_div(d, 5, !d[0]);
      run_div(d, 30, d[0]);
      run_div(d, 63, 1'b0);
    end
    run_div(1, 2, 1'b1);
    run_div(0, 0, 1'b0);

    // R6: change in the enable-rise cycle and while running is ignored
    @(negedge clk);
    en = 1'b0; cfg_div = 2'd0; cfg_brg = 6'd5; cpol = 1'b0;
    repeat (2) @(negedge clk);
    en = 1'b1; cfg_brg = 6'd9;
    half(c);
    chk(c == 12, "R6", c, 12);
    cfg_brg = 6'd20; cfg_div = 2'd1;
    half(c);
    chk(c == 12, "R6", c, 12);
    chk(act_brg == 5 && act_div == 0, "R6", {act_div, act_brg}, 5);
    en = 1'b0;
    @(negedge clk);
    chk(act_brg == 20 && act_div == 1, "R6", {act_div, act_brg}, {2'd1, 6'd20});

    finish_run();
  end
endmodule